// File: doc/BRIEF.md
# Compacting Dual-Issue Instruction Queue

This block is a four-entry instruction holding queue between a predecode stage and an issue stage. Each cycle it may take in zero, one or two instructions from two predecode lanes. It always shows its two oldest entries to the issue stage, and the issue stage may take either of them, both, or neither. Every instruction is carried as an opaque 32-bit word with a sequence tag. The queue never decodes the word.

The queue stays packed toward entry 0 in program order with no gaps. When entries leave, the ones that remain move down in the same clock. New arrivals are placed directly behind the oldest surviving entry, so a slot that is being vacated in a cycle can be refilled in that same cycle. The issue stage may take entry 1 while it holds entry 0. In that case entry 0 keeps its instruction and the younger entries move down one place.

The queue tells predecode how many entries are free in its present state. It also reports each cycle which offered instructions it actually took. A flush empties the queue in one clock.

Top module: `dq_queue`

## Requirements
- R1: After reset both presented slots are invalid and the free-entry count equals the depth (4).
- R2: Up to two instructions are written per clock. Lane 0 is older than lane 1. When only lane 1 offers, its instruction is written as the next entry.
- R3: Valid entries always occupy a contiguous run starting at entry 0, so slot 1 is never valid while slot 0 is empty.
- R4: New instructions are placed behind every surviving older entry, including entries that issue in the same cycle, and program order is preserved.
- R5: Only entries 0 and 1 can issue. An issue strobe on an empty slot has no effect.
- R6: When slot 1 issues while slot 0 is held, slot 0 keeps its instruction and all younger entries move down by one.
- R7: The free-entry output equals the depth minus the number of valid entries. Lane 0 is accepted when at least one entry is free after this cycle's issues. Lane 1 is accepted when at least one more entry is free beyond any taken by lane 0. An offer that is not accepted is not written.
- R8: Flush empties the queue on the next clock and overrides writes and issues in its cycle. Nothing is accepted during a flush.
- R9: Every accepted instruction leaves exactly once, through issue or flush, and no sequence tag is issued twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| in_v0 | input | 1 | Lane 0 offers an instruction |
| in_instr0 | input | IW | Lane 0 instruction word |
| in_seq0 | input | SEQW | Lane 0 sequence tag |
| in_v1 | input | 1 | Lane 1 offers an instruction |
| in_instr1 | input | IW | Lane 1 instruction word |
| in_seq1 | input | SEQW | Lane 1 sequence tag |
| in_acc0 | output | 1 | Lane 0 offer taken this cycle |
| in_acc1 | output | 1 | Lane 1 offer taken this cycle |
| space | output | CW | Number of empty entries in the current state |
| slot0_v | output | 1 | Oldest entry valid |
| slot0_instr | output | IW | Oldest entry word |
| slot0_seq | output | SEQW | Oldest entry tag |
| slot1_v | output | 1 | Second entry valid |
| slot1_instr | output | IW | Second entry word |
| slot1_seq | output | SEQW | Second entry tag |
| iss0 | input | 1 | Issue stage takes slot 0 |
| iss1 | input | 1 | Issue stage takes slot 1 |

## Verification
The bench builds the queue with its default depth of 4 and a 32-bit word, and widens the sequence tag to 16 bits. With 16 bits, a few thousand random cycles never wrap the tag, so any lost or duplicated instruction shows up as a missing or repeated tag. The default depth lets the queue become full within a couple of cycles. This makes refusal of lane 1, same-cycle refill of a full queue and slot-1-alone issue with three or four entries present all common events, both in the directed cases and in the random phase.

// File: rtl/dq_pkg.sv
package dq_pkg;

  // number of set bits of m strictly below position i
  function automatic int unsigned ones_below(input logic [31:0] m, input int unsigned i);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < i && m[k]) n++;
    end
    return n;
  endfunction

  // acceptance of the two lanes given the room left after issue
  function automatic logic [1:0] lane_grant(input logic v0, input logic v1,
                                            input int unsigned room);
    logic [1:0] g;
    g[0] = v0 && (room >= 1);
    g[1] = v1 && (room >= (v0 ? 2 : 1));
    return g;
  endfunction

endpackage

// File: rtl/dq_survive.sv
module dq_survive #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] vld,
  input  logic             take0,
  input  logic             take1,
  output logic [DEPTH-1:0] keep,
  output logic [CW-1:0]    n_keep
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_keep
    if (i == 0) begin : g_s0
      assign keep[i] = vld[i] & ~take0;
    end else if (i == 1) begin : g_s1
      assign keep[i] = vld[i] & ~take1;
    end else begin : g_sn
      assign keep[i] = vld[i];
    end
  end

  assign n_keep = CW'($countones(keep));
endmodule

// File: rtl/dq_route.sv
module dq_route
  import dq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int EW    = 40,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][EW-1:0] ent,
  input  logic [DEPTH-1:0]         keep,
  input  logic [CW-1:0]            n_keep,
  input  logic                     wa_v,
  input  logic [EW-1:0]            wa,
  input  logic                     wb_v,
  input  logic [EW-1:0]            wb,
  output logic [DEPTH-1:0]         vld_n,
  output logic [DEPTH-1:0][EW-1:0] ent_n
);
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      vld_n[j] = 1'b0;
      ent_n[j] = '0;
      // surviving entry that compacts into position j
      for (int i = 0; i < DEPTH; i++) begin
        if (keep[i] && ones_below(32'(keep), i) == j) begin
          vld_n[j] = 1'b1;
          ent_n[j] = ent[i];
        end
      end
      // new arrivals sit right behind the survivors
      if (wa_v && int'(n_keep) == j) begin
        vld_n[j] = 1'b1;
        ent_n[j] = wa;
      end
      if (wb_v && int'(n_keep) + 1 == j) begin
        vld_n[j] = 1'b1;
        ent_n[j] = wb;
      end
    end
  end
endmodule

// File: rtl/dq_queue.sv
module dq_queue
  import dq_pkg::*;
#(
  parameter int IW    = 32,
  parameter int SEQW  = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_v0,
  input  logic [IW-1:0]   in_instr0,
  input  logic [SEQW-1:0] in_seq0,
  input  logic            in_v1,
  input  logic [IW-1:0]   in_instr1,
  input  logic [SEQW-1:0] in_seq1,
  output logic            in_acc0,
  output logic            in_acc1,
  output logic [CW-1:0]   space,
  output logic            slot0_v,
  output logic [IW-1:0]   slot0_instr,
  output logic [SEQW-1:0] slot0_seq,
  output logic            slot1_v,
  output logic [IW-1:0]   slot1_instr,
  output logic [SEQW-1:0] slot1_seq,
  input  logic            iss0,
  input  logic            iss1
);
  localparam int EW = IW + SEQW;

  logic [DEPTH-1:0]         vld_q, vld_n;
  logic [DEPTH-1:0][EW-1:0] ent_q, ent_n;
  logic [DEPTH-1:0]         keep;
  logic [CW-1:0]            n_keep;
  logic [CW-1:0]            room;
  logic [1:0]               grant;

  // named events for the checker
  logic iss0_eff, iss1_eff;
  assign iss0_eff = iss0 & vld_q[0] & ~flush;
  assign iss1_eff = iss1 & vld_q[1] & ~flush;

  dq_survive #(.DEPTH(DEPTH), .CW(CW)) u_survive (
    .vld    (vld_q),
    .take0  (iss0_eff),
    .take1  (iss1_eff),
    .keep   (keep),
    .n_keep (n_keep)
  );

  assign room    = CW'(DEPTH) - n_keep;
  assign grant   = flush ? 2'b00 : lane_grant(in_v0, in_v1, int'(room));
  assign in_acc0 = grant[0];
  assign in_acc1 = grant[1];

  logic          wa_v, wb_v;
  logic [EW-1:0] wa, wb;
  assign wa_v = in_acc0 | in_acc1;
  assign wa   = in_acc0 ? {in_seq0, in_instr0} : {in_seq1, in_instr1};
  assign wb_v = in_acc0 & in_acc1;
  assign wb   = {in_seq1, in_instr1};

  dq_route #(.DEPTH(DEPTH), .EW(EW), .CW(CW)) u_route (
    .ent    (ent_q),
    .keep   (keep),
    .n_keep (n_keep),
    .wa_v   (wa_v),
    .wa     (wa),
    .wb_v   (wb_v),
    .wb     (wb),
    .vld_n  (vld_n),
    .ent_n  (ent_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
      ent_q <= '0;
    end else begin
      vld_q <= vld_n;
      ent_q <= ent_n;
    end
  end

  assign space       = CW'(DEPTH) - CW'($countones(vld_q));
  assign slot0_v     = vld_q[0];
  assign slot0_instr = ent_q[0][IW-1:0];
  assign slot0_seq   = ent_q[0][EW-1:IW];
  assign slot1_v     = vld_q[1];
  assign slot1_instr = ent_q[1][IW-1:0];
  assign slot1_seq   = ent_q[1][EW-1:IW];
endmodule

// File: rtl/dq_queue_chk.sv
module dq_queue_chk #(
  parameter int DEPTH = 4,
  parameter int EW    = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [DEPTH-1:0] vld,
  input logic [EW-1:0]    head,
  input logic             iss0_eff,
  input logic             iss1_eff,
  input logic             in_v0,
  input logic             in_v1,
  input logic             in_acc0,
  input logic             in_acc1
);
  int cnt_now, delta;
  assign cnt_now = $countones(vld);
  assign delta   = int'(in_acc0) + int'(in_acc1) - int'(iss0_eff) - int'(iss1_eff);

  // R3: valid entries form a run from entry 0
  a_r3_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld & DEPTH'(vld + 1'b1)) == '0));

  // R8: flush empties the queue and blocks acceptance
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));
  a_r8_flush_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!in_acc0 && !in_acc1));

  // R6: slot 1 issuing alone leaves the head in place
  a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1_eff && !iss0_eff && !flush) |=> (vld[0] && head == $past(head)));

  // R9: occupancy moves only by accepted and issued entries
  a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (cnt_now == $past(cnt_now + delta)));

  // R7: nothing is accepted that was not offered
  a_r7_acc_offered: assert property (@(posedge clk) disable iff (!rst_n)
    ((!in_acc0 || in_v0) && (!in_acc1 || in_v1)));
endmodule

bind dq_queue dq_queue_chk #(.DEPTH(DEPTH), .EW(EW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .vld      (vld_q),
  .head     (ent_q[0]),
  .iss0_eff (iss0_eff),
  .iss1_eff (iss1_eff),
  .in_v0    (in_v0),
  .in_v1    (in_v1),
  .in_acc0  (in_acc0),
  .in_acc1  (in_acc1)
);

// File: tb/dq_queue_bench.sv
module dq_queue_bench;
  localparam int IW = 32, SEQW = 16, DEPTH = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic in_v0 = 1'b0, in_v1 = 1'b0, iss0 = 1'b0, iss1 = 1'b0;
  logic [IW-1:0] in_instr0 = '0, in_instr1 = '0;
  logic [SEQW-1:0] in_seq0 = '0, in_seq1 = '0;
  logic in_acc0, in_acc1, slot0_v, slot1_v;
  logic [CW-1:0] space;
  logic [IW-1:0] slot0_instr, slot1_instr;
  logic [SEQW-1:0] slot0_seq, slot1_seq;

  always #4 clk = ~clk;

  dq_queue #(.IW(IW), .SEQW(SEQW), .DEPTH(DEPTH)) u_dq_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_v0(in_v0), .in_instr0(in_instr0), .in_seq0(in_seq0),
    .in_v1(in_v1), .in_instr1(in_instr1), .in_seq1(in_seq1),
    .in_acc0(in_acc0), .in_acc1(in_acc1), .space(space),
    .slot0_v(slot0_v), .slot0_instr(slot0_instr), .slot0_seq(slot0_seq),
    .slot1_v(slot1_v), .slot1_instr(slot1_instr), .slot1_seq(slot1_seq),
    .iss0(iss0), .iss1(iss1)
  );

  int errors = 0, checks = 0;
  int next_seq = 0;
  int n_acc = 0, n_iss = 0, n_flushed = 0;
  int unsigned mq[$];       // reference queue of sequence tags
  bit seen[int];

  function automatic logic [IW-1:0] word_of(input int s);
    return IW'(s) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_state(input string req);
    int n = mq.size();
    chk(space == CW'(DEPTH - n), "R7", "space", space, DEPTH - n);
    chk(slot0_v == (n > 0), req, "slot0_v", slot0_v, n > 0);
    chk(slot1_v == (n > 1), "R3", "slot1_v", slot1_v, n > 1);
    if (n > 0) begin
      chk(slot0_seq == SEQW'(mq[0]), req, "slot0_seq", slot0_seq, mq[0]);
      chk(slot0_instr == word_of(mq[0]), req, "slot0_instr", slot0_instr, word_of(mq[0]));
    end
    if (n > 1) begin
      chk(slot1_seq == SEQW'(mq[1]), req, "slot1_seq", slot1_seq, mq[1]);
      chk(slot1_instr == word_of(mq[1]), req, "slot1_instr", slot1_instr, word_of(mq[1]));
    end
  endtask

  // one clock: drive at negedge, check, let the edge happen, update model
  task automatic step(input bit f, input bit v0, input bit v1,
                      input bit s0, input bit s1, input string req);
    int n, surv, room, a;
    bit e0, e1, t0, t1;
    int unsigned nq[$];
    @(negedge clk);
    flush = f; in_v0 = v0; in_v1 = v1; iss0 = s0; iss1 = s1;
    in_seq0 = SEQW'(next_seq); in_instr0 = word_of(next_seq);
    in_seq1 = SEQW'(v0 ? next_seq + 1 : next_seq);
    in_instr1 = word_of(v0 ? next_seq + 1 : next_seq);
    #1;
    cmp_state(req);
    n  = mq.size();
    t0 = !f && s0 && n > 0;      // R5: strobe on empty slot ignored
    t1 = !f && s1 && n > 1;
    surv = n - int'(t0) - int'(t1);
    room = DEPTH - surv;
    e0 = !f && v0 && room >= 1;
    e1 = !f && v1 && room >= (v0 ? 2 : 1);
    chk(in_acc0 == e0, "R7", "in_acc0", in_acc0, e0);
    chk(in_acc1 == e1, "R7", "in_acc1", in_acc1, e1);
    @(posedge clk);
    if (f) begin
      n_flushed += n;
      mq.delete();
    end else begin
      for (int i = 0; i < n; i++) begin
        if ((i == 0 && t0) || (i == 1 && t1)) begin
          chk(!seen.exists(int'(mq[i])), "R9", "duplicate issue", mq[i], -1);
          seen[int'(mq[i])] = 1'b1;
          n_iss++;
        end else nq.push_back(mq[i]);
      end
      a = int'(e0) + int'(e1);
      for (int k = 0; k < a; k++) nq.push_back(next_seq + k);
      next_seq += a;
      n_acc += a;
      mq = nq;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(slot0_v == 1'b0 && slot1_v == 1'b0, "R1", "valids after reset", {slot0_v, slot1_v}, 0);
    chk(space == CW'(DEPTH), "R1", "space after reset", space, DEPTH);
    rst_n = 1'b1;

    step(0, 1, 1, 0, 0, "R2");    // two into empty queue
    step(0, 0, 1, 0, 0, "R2");    // lane 1 alone
    step(0, 1, 1, 0, 0, "R7");    // room 1: lane 1 refused
    step(0, 0, 0, 0, 1, "R6");    // full; slot 1 leaves alone
    step(0, 0, 0, 0, 0, "R6");    // head kept, younger shifted
    step(0, 1, 1, 1, 1, "R4");    // both leave, same-cycle refill
    step(0, 1, 1, 0, 1, "R4");    // slot1 leaves, refill behind head
    step(0, 1, 1, 1, 1, "R8");    // flush overrides all
    step(1, 1, 1, 1, 1, "R8");
    step(0, 0, 0, 1, 1, "R5");    // strobes on empty queue
    step(0, 1, 0, 0, 1, "R5");    // one entry; slot1 strobe ignored
    step(0, 0, 0, 0, 1, "R5");
    step(0, 0, 0, 1, 0, "R4");

    for (int c = 0; c < 3000; c++) begin
      step(($urandom % 40) == 0, $urandom % 4 != 0, $urandom % 3 != 0,
           $urandom % 3 == 0, $urandom % 3 == 0, "R4");
    end
    for (int c = 0; c < 4; c++) step(0, 0, 0, 1, 1, "R4");

    @(negedge clk); #1;
    cmp_state("R4");
    chk(n_acc == n_iss + n_flushed + mq.size(), "R9", "conservation",
        n_acc, n_iss + n_flushed + mq.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule